// File: doc/BRIEF.md
# ECC Error Capture Status Register

This block sits beside a memory controller's ECC checker and records the details of the first memory error that checker reports. Each report is a one-cycle strobe that says whether the error was corrected (single-bit) or uncorrectable (multi-bit) and carries the faulting byte address and the 8-bit syndrome of the 72-bit word. Only the upper 19 address bits are kept, so the captured location has a granularity of 8 KiB.

Software sees one 32-bit register. It holds the captured address and syndrome, two write-one-to-clear status flags, two interrupt enables and a scrub disable. Once a first error is held, capture freezes until software clears both flags with a single write. A captured single-bit error can raise a one-cycle non-maskable interrupt pulse, and a captured multi-bit error can raise a one-cycle system-error pulse. Independently of capture, every corrected read asks the controller to write the corrected data back unless scrubbing is disabled.

Top module: `ecc_err_capture`

## Requirements
- R1: After synchronous reset the register reads 0x0000_0000 and nmi_pulse, serr_pulse and scrub_req are 0; scrubbing is thereby enabled.
- R2: A report accepted while both flags are clear is stored at the next clock edge: err_addr[31:13] in bits 30:12, err_syndrome in bits 11:4, and bit 0 set for a single-bit report (err_multi=0) or bit 1 set for a multi-bit report (err_multi=1); the other flag reads 0.
- R3: While bit 0 or bit 1 is set, later reports leave bits 30:0 unchanged.
- R4: A write with write data bits 1 and 0 both 1 clears both flags; a write with only one of them at 1, or neither, leaves both flags unchanged. Clearing leaves bits 30:4 at their last captured value.
- R5: Bits 31 (scrub disable), 3 (system-error enable) and 2 (interrupt enable) take the written value on every write; writes to bits 30:4 are ignored.
- R6: nmi_pulse is 1 for exactly the one cycle after a single-bit report is captured while bit 2 is 1, and stays 0 for a capture while bit 2 is 0.
- R7: serr_pulse is 1 for exactly the one cycle after a multi-bit report is captured while bit 3 is 1, and stays 0 otherwise.
- R8: scrub_req is 1 for the one cycle after any single-bit report, captured or not, while bit 31 is 0; it stays 0 when bit 31 is 1 and after any multi-bit report.
- R9: A report that arrives in the same cycle as a clearing write is captured, replacing the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | One-cycle error report strobe from the ECC checker |
| err_multi | input | 1 | 1 = multi-bit (uncorrectable), 0 = single-bit (corrected) |
| err_addr | input | 32 | Faulting byte address |
| err_syndrome | input | 8 | Syndrome of the faulting word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Current register contents |
| nmi_pulse | output | 1 | One-cycle interrupt on a captured single-bit error |
| serr_pulse | output | 1 | One-cycle system error on a captured multi-bit error |
| scrub_req | output | 1 | One-cycle request to write corrected data back |

## Verification
A software clear and a new error report can land in the same clock edge, and the order between them decides whether the new error is lost. The bench provokes this by holding a multi-bit capture, then issuing a write with both flag bits set together with a single-bit report in one cycle. It judges the result by reading back the register in the following cycle, which must show the new address, syndrome and bit 0 alone, and by checking that only the enabled pulse fires.

// File: rtl/ecc_cap_pkg.sv
// Package: field positions and widths of the ECC error capture register.
// Assumes a 32-bit register and a 32-bit byte address of which the upper
// bits are kept.
package ecc_cap_pkg;
    localparam int REG_W        = 32;
    localparam int ADDR_W       = 32;
    localparam int SYN_W        = 8;
    localparam int SCRUB_DIS_B  = 31;
    localparam int ADDR_HI_B    = 30;
    localparam int ADDR_LO_B    = 12;
    localparam int SYN_HI_B     = 11;
    localparam int SYN_LO_B     = 4;
    localparam int SERR_EN_B    = 3;
    localparam int NMI_EN_B     = 2;
    localparam int MBE_B        = 1;
    localparam int SBE_B        = 0;
    localparam int KEEP_W       = ADDR_HI_B - ADDR_LO_B + 1;
    localparam int DROP_W       = ADDR_W - KEEP_W;
    localparam int NFLAG        = 2;

    typedef struct packed {
        logic              scrub_dis;
        logic              serr_en;
        logic              nmi_en;
    } cap_ctl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
// ecc_cap_ctrl: holds the software enables and decodes register writes.
// Assumes a write updates all read/write bits at once; the clear request
// is raised only when both flag bits are written as 1 together.
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wd_scrub_dis,
    input  logic              wd_serr_en,
    input  logic              wd_nmi_en,
    input  logic [NFLAG-1:0]  wd_flags,
    output cap_ctl_t          ctl,
    output logic              clr_req
);
    cap_ctl_t ctl_q;

    // Enable register: reset to all zero, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q.scrub_dis <= wd_scrub_dis;
            ctl_q.serr_en   <= wd_serr_en;
            ctl_q.nmi_en    <= wd_nmi_en;
        end
    end

    // Clear decode: both flag bits must be 1 in the same write.
    always_comb begin
        clr_req = wr_en && (&wd_flags);
    end

    assign ctl = ctl_q;

    a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q.nmi_en == $past(wd_nmi_en)) && (ctl_q.serr_en == $past(wd_serr_en)));
endmodule

// File: rtl/ecc_cap_latch.sv
// ecc_cap_latch: stores the first error's address, syndrome and type.
// Assumes a report lasts one cycle; a clear in the same cycle is applied
// before the report is judged, so the report is then captured.
module ecc_cap_latch
    import ecc_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_valid,
    input  logic               err_multi,
    input  logic [KEEP_W-1:0]  err_addr_hi,
    input  logic [SYN_W-1:0]   err_syn,
    input  logic               clr_req,
    output logic [KEEP_W-1:0]  cap_addr,
    output logic [SYN_W-1:0]   cap_syn,
    output logic [NFLAG-1:0]   cap_flags,
    output logic               cap_fire
);
    logic [KEEP_W-1:0] addr_q;
    logic [SYN_W-1:0]  syn_q;
    logic [NFLAG-1:0]  flags_q;
    logic              open_w;

    // Capture window: open when no flag is held or this cycle clears them.
    always_comb begin
        open_w   = (flags_q == '0) || clr_req;
        cap_fire = err_valid && open_w;
    end

    // Capture registers: load on accepted report, flags drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            syn_q   <= '0;
            flags_q <= '0;
        end else if (cap_fire) begin
            addr_q         <= err_addr_hi;
            syn_q          <= err_syn;
            flags_q[SBE_B] <= !err_multi;
            flags_q[MBE_B] <= err_multi;
        end else if (clr_req) begin
            flags_q <= '0;
        end
    end

    assign cap_addr  = addr_q;
    assign cap_syn   = syn_q;
    assign cap_flags = flags_q;

    a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_q));

    a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) && !clr_req |=> $stable(addr_q) && $stable(syn_q) && $stable(flags_q));

    a_r9_clear_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && err_valid |=> (flags_q != '0) && (addr_q == $past(err_addr_hi)));

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && !err_valid |=> flags_q == '0);
endmodule

// File: rtl/ecc_cap_events.sv
// ecc_cap_events: registered one-cycle interrupt, system-error and scrub
// pulses. Assumes enables are sampled as they stand in the report cycle.
module ecc_cap_events
    import ecc_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      err_valid,
    input  logic      err_multi,
    input  logic      cap_fire,
    input  cap_ctl_t  ctl,
    output logic      nmi_pulse,
    output logic      serr_pulse,
    output logic      scrub_req
);
    // Pulse registers: each fires for the cycle after its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse  <= 1'b0;
            serr_pulse <= 1'b0;
            scrub_req  <= 1'b0;
        end else begin
            nmi_pulse  <= cap_fire && !err_multi && ctl.nmi_en;
            serr_pulse <= cap_fire && err_multi && ctl.serr_en;
            scrub_req  <= err_valid && !err_multi && !ctl.scrub_dis;
        end
    end

    a_r8_scrub_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl.scrub_dis) |-> !scrub_req);

    a_r6_nmi_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && serr_pulse));
endmodule

// File: rtl/ecc_err_capture.sv
// ecc_err_capture: top of the ECC error capture status register.
// Assumes the ECC checker presents one report per cycle at most and that
// software accesses the register through a simple write strobe.
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_valid,
    input  logic               err_multi,
    input  logic [ADDR_W-1:0]  err_addr,
    input  logic [SYN_W-1:0]   err_syndrome,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic               nmi_pulse,
    output logic               serr_pulse,
    output logic               scrub_req
);
    cap_ctl_t           ctl;
    logic               clr_req;
    logic               cap_fire;
    logic [KEEP_W-1:0]  cap_addr;
    logic [SYN_W-1:0]   cap_syn;
    logic [NFLAG-1:0]   cap_flags;
    logic               unused_addr_lo;
    logic               unused_wd_mid;

    assign unused_addr_lo = ^err_addr[DROP_W-1:0];
    assign unused_wd_mid  = ^reg_wr_data[ADDR_HI_B:SYN_LO_B];

    ecc_cap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .wd_scrub_dis (reg_wr_data[SCRUB_DIS_B]),
        .wd_serr_en   (reg_wr_data[SERR_EN_B]),
        .wd_nmi_en    (reg_wr_data[NMI_EN_B]),
        .wd_flags     (reg_wr_data[MBE_B:SBE_B]),
        .ctl          (ctl),
        .clr_req      (clr_req)
    );

    ecc_cap_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_valid   (err_valid),
        .err_multi   (err_multi),
        .err_addr_hi (err_addr[ADDR_W-1:DROP_W]),
        .err_syn     (err_syndrome),
        .clr_req     (clr_req),
        .cap_addr    (cap_addr),
        .cap_syn     (cap_syn),
        .cap_flags   (cap_flags),
        .cap_fire    (cap_fire)
    );

    ecc_cap_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_valid  (err_valid),
        .err_multi  (err_multi),
        .cap_fire   (cap_fire),
        .ctl        (ctl),
        .nmi_pulse  (nmi_pulse),
        .serr_pulse (serr_pulse),
        .scrub_req  (scrub_req)
    );

    // Readback assembly: fields placed at their register positions.
    always_comb begin
        reg_rd_data                        = '0;
        reg_rd_data[SCRUB_DIS_B]           = ctl.scrub_dis;
        reg_rd_data[ADDR_HI_B:ADDR_LO_B]   = cap_addr;
        reg_rd_data[SYN_HI_B:SYN_LO_B]     = cap_syn;
        reg_rd_data[SERR_EN_B]             = ctl.serr_en;
        reg_rd_data[NMI_EN_B]              = ctl.nmi_en;
        reg_rd_data[MBE_B:SBE_B]           = cap_flags;
    end

    a_r6_nmi_has_sbe: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> reg_rd_data[SBE_B] && $past(reg_rd_data[NMI_EN_B]));

    a_r7_serr_has_mbe: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> reg_rd_data[MBE_B] && $past(reg_rd_data[SERR_EN_B]));

    a_r8_no_scrub_on_mbe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_valid && err_multi) |-> !scrub_req);
endmodule

// File: tb/test_ecc_err_capture.sv
`timescale 1ns/1ps
module test_ecc_err_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        err_valid, err_multi;
    logic [31:0] err_addr;
    logic [7:0]  err_syndrome;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        nmi_pulse, serr_pulse, scrub_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ecc_err_capture i_ecc_err_capture (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_multi(err_multi),
        .err_addr(err_addr), .err_syndrome(err_syndrome), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .nmi_pulse(nmi_pulse),
        .serr_pulse(serr_pulse), .scrub_req(scrub_req)
    );

    function automatic logic [31:0] pack(input logic [31:0] a, input logic [7:0] s,
                                         input logic [1:0] f, input logic [31:0] c);
        return (c & 32'h8000_000C) | {1'b0, a[31:13], s, 2'b00, f};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One clock: inputs set after an edge, results sampled 1 ns after next edge.
    task automatic cyc(input logic v, input logic m, input logic [31:0] a, input logic [7:0] s,
                       input logic we, input logic [31:0] wd);
        err_valid = v; err_multi = m; err_addr = a; err_syndrome = s;
        reg_wr_en = we; reg_wr_data = wd;
        @(posedge clk); #1;
        err_valid = 1'b0; reg_wr_en = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        idle();
        chk("R1 reg", reg_rd_data, 32'h0);
        chk("R1 pulses", {29'h0, nmi_pulse, serr_pulse, scrub_req}, 32'h0);
    endtask

    task automatic t_single_capture();
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0004);
        cyc(1'b1, 1'b0, 32'hDEAD_B123, 8'h5A, 1'b0, 32'h0);
        chk("R2 single", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
        chk("R6 nmi", {31'h0, nmi_pulse}, 32'h1);
        chk("R8 scrub", {31'h0, scrub_req}, 32'h1);
        chk("R7 no serr", {31'h0, serr_pulse}, 32'h0);
        idle();
        chk("R6 nmi one cycle", {31'h0, nmi_pulse}, 32'h0);
        chk("R8 scrub one cycle", {31'h0, scrub_req}, 32'h0);
    endtask

    task automatic t_freeze();
        cyc(1'b1, 1'b1, 32'h1234_5678, 8'hC3, 1'b0, 32'h0);
        chk("R3 freeze mbe", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
        cyc(1'b1, 1'b0, 32'h0F0F_0000, 8'h11, 1'b0, 32'h0);
        chk("R3 freeze sbe", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
        chk("R6 no nmi when frozen", {31'h0, nmi_pulse}, 32'h0);
        chk("R8 scrub when frozen", {31'h0, scrub_req}, 32'h1);
    endtask

    task automatic t_partial_clear();
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0005);
        chk("R4 bit0 only", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0006);
        chk("R4 bit1 only", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0004);
        chk("R4 zero write", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b01, 32'h4));
    endtask

    task automatic t_full_clear_and_ro();
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h7FFF_FFF3);
        chk("R4 clear keeps fields", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b00, 32'h0));
        chk("R5 ro ignored", reg_rd_data & 32'h7FFF_FFF0, pack(32'hDEAD_B123, 8'h5A, 2'b00, 32'h0));
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h8000_000C);
        chk("R5 enables rw", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b00, 32'h8000_000C));
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0008);
        chk("R5 enables rewrite", reg_rd_data, pack(32'hDEAD_B123, 8'h5A, 2'b00, 32'h8));
    endtask

    task automatic t_multi();
        cyc(1'b1, 1'b1, 32'hFFFF_E000, 8'hA5, 1'b0, 32'h0);
        chk("R2 multi", reg_rd_data, pack(32'hFFFF_E000, 8'hA5, 2'b10, 32'h8));
        chk("R7 serr", {31'h0, serr_pulse}, 32'h1);
        chk("R8 no scrub on mbe", {31'h0, scrub_req}, 32'h0);
        chk("R6 no nmi on mbe", {31'h0, nmi_pulse}, 32'h0);
        idle();
        chk("R7 serr one cycle", {31'h0, serr_pulse}, 32'h0);
    endtask

    task automatic t_same_cycle();
        cyc(1'b1, 1'b0, 32'h0000_4000, 8'h3C, 1'b1, 32'h0000_000B);
        chk("R9 clear then capture", reg_rd_data, pack(32'h0000_4000, 8'h3C, 2'b01, 32'h8));
        chk("R6 nmi disabled", {31'h0, nmi_pulse}, 32'h0);
        chk("R7 no serr on sbe", {31'h0, serr_pulse}, 32'h0);
    endtask

    task automatic t_scrub_disabled();
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h8000_0003);
        cyc(1'b1, 1'b0, 32'h2468_A000, 8'h77, 1'b0, 32'h0);
        chk("R8 scrub disabled", {31'h0, scrub_req}, 32'h0);
        chk("R2 capture with scrub off", reg_rd_data, pack(32'h2468_A000, 8'h77, 2'b01, 32'h8000_0000));
        cyc(1'b0, 1'b0, 32'h0, 8'h0, 1'b1, 32'h0000_0003);
        cyc(1'b1, 1'b0, 32'h0000_0000, 8'h01, 1'b0, 32'h0);
        chk("R8 scrub re-enabled", {31'h0, scrub_req}, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        err_valid = 1'b0; err_multi = 1'b0; err_addr = '0; err_syndrome = '0;
        reg_wr_en = 1'b0; reg_wr_data = '0; rst_n = 1'b0;
        t_reset();
        t_single_capture();
        t_freeze();
        t_partial_clear();
        t_full_clear_and_ro();
        t_multi();
        t_same_cycle();
        t_scrub_disabled();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule